// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

The block produces periodic DRAM refresh requests from a programmable interval timer and turns each one into a single refresh bus cycle. A refresh bus cycle is taken only at the end of a machine cycle in which the bus owner grants refresh. Each completed cycle advances an 8-bit refresh row address. The DRAM timing waveforms, the processor core and priority against other bus masters belong to neighbouring logic.

While the processor sleeps, the interval timer keeps running but no refresh cycle is issued. Any number of timer expiries during sleep leave exactly one request pending. That request is served at the first granted machine-cycle end after sleep is left. From then on the interval timer alone sets the refresh timing. Because the row address moves only on completed cycles, successive refresh cycles always use consecutive rows, however many requests were dropped.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, req_o and active_o are 0 and row_o is 0.
- R2: The interval timer expires once every interval_i+1 clock cycles, counting from reset release. An expiry makes req_o high from the next cycle on, provided sleep_i is low.
- R3: While sleep_i is high, req_o is 0. active_o is 0 in every cycle that follows a cycle with sleep_i high.
- R4: Several timer expiries during sleep leave a single pending request. After sleep ends they yield one refresh cycle, not one per expiry.
- R5: A request pending at sleep exit is served at the first cycle with mc_end_i and grant_i both high after sleep_i falls.
- R6: Outside sleep, req_o stays high until a cycle with mc_end_i=1 and grant_i=1. In the next cycle active_o is high for one cycle and req_o falls, unless a new expiry occurred in the serving cycle.
- R7: A timer expiry while a request is already pending merges with it. It does not create a second refresh cycle.
- R8: row_o increases by exactly one in each cycle where active_o is high, wraps from 255 to 0, and is otherwise unchanged.
- R9: The interval timer keeps counting during sleep. Expiry times do not depend on sleep_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| interval_i | input | 12 | Refresh period minus one, in clock cycles |
| sleep_i | input | 1 | Processor sleep mode |
| mc_end_i | input | 1 | Last cycle of a machine cycle |
| grant_i | input | 1 | Bus granted for a refresh cycle |
| req_o | output | 1 | Refresh cycle requested |
| active_o | output | 1 | One-cycle strobe: a refresh cycle was taken |
| row_o | output | 8 | Refresh row address |

## Verification
The assertions assume that interval_i is held constant outside reset. They also assume that mc_end_i and grant_i are meaningful only as a pair, with no meaning given to the grant alone. The stimulus changes interval_i only while reset is asserted, and drives all other inputs shortly after each rising edge. Grant and machine-cycle end patterns run from permanently high to sparse. Sleep windows are long enough to span several timer expiries, so that merging and the wake-up replay are both exercised.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int unsigned RFSH_ROW_W = 8;
  localparam int unsigned RFSH_IVL_W = 12;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned IW = refresh_pkg::RFSH_IVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ivl_i,
  output logic          tick_o
);
  logic [IW-1:0] cnt_q;

  // >= keeps the timer bounded if the period is lowered mid-count
  assign tick_o = (cnt_q >= ivl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sleep_i,
  input  logic mc_end_i,
  input  logic grant_i,
  output logic req_o,
  output logic fire_o,
  output logic active_o
);
  logic pend_q, act_q;

  assign req_o  = pend_q & ~sleep_i;
  assign fire_o = req_o & mc_end_i & grant_i;

  // single latch: expiries during sleep or while pending collapse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= tick_i | (pend_q & ~fire_o);
      act_q  <= fire_o;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned RW = refresh_pkg::RFSH_ROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output logic [RW-1:0] row_o
);
  logic [RW-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (fire_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned IW = refresh_pkg::RFSH_IVL_W,
  parameter int unsigned RW = refresh_pkg::RFSH_ROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] interval_i,
  input  logic          sleep_i,
  input  logic          mc_end_i,
  input  logic          grant_i,
  output logic          req_o,
  output logic          active_o,
  output logic [RW-1:0] row_o
);
  logic tick, fire;

  rfsh_interval_timer #(.IW(IW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ivl_i (interval_i),
    .tick_o(tick)
  );

  rfsh_pending u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .sleep_i (sleep_i),
    .mc_end_i(mc_end_i),
    .grant_i (grant_i),
    .req_o   (req_o),
    .fire_o  (fire),
    .active_o(active_o)
  );

  rfsh_row_ctr #(.RW(RW)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .row_o (row_o)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          mc_end_i,
  input logic          grant_i,
  input logic          req_o,
  input logic          active_o,
  input logic [RW-1:0] row_o
);
  assert_no_cycle_in_sleep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active_o);

  assert_strobe_needs_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !(mc_end_i && grant_i)) |=> !active_o);

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !(mc_end_i && grant_i)) |=> (req_o || sleep_i));

  assert_row_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (row_o == RW'($past(row_o) + 1'b1)));

  assert_row_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> $stable(row_o));

  assert_served_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && mc_end_i && grant_i) |=> active_o);
endmodule

bind refresh_sched refresh_sched_chk #(.RW(RW)) chk_i (.*);

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 12;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] interval = 12'd3;
  logic sleep = 1'b0, mc_end = 1'b0, grant = 1'b0;
  logic req, active;
  logic [RW-1:0] row;

  int vectors = 0, errors = 0, cycles = 0;
  int m_cnt = 0, m_row = 0;
  bit m_pend = 0, m_act = 0;
  string tag = "R1";
  int acts_after_wake = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .interval_i(interval), .sleep_i(sleep),
    .mc_end_i(mc_end), .grant_i(grant), .req_o(req), .active_o(active), .row_o(row)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_row = 0; m_pend = 0; m_act = 0;
    end else begin
      bit tick, fire;
      tick = (m_cnt >= int'(interval));
      fire = m_pend && !sleep && mc_end && grant;
      m_act = fire;
      if (fire) m_row = (m_row + 1) % 256;
      m_pend = tick || (m_pend && !fire);
      m_cnt = tick ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    bit e_req;
    cycles++;
    e_req = m_pend && !sleep;
    vectors++;
    if (req !== e_req || active !== m_act || int'(row) != m_row) begin
      errors++;
      $display("FAIL %s cycle %0d: req/act/row = %b/%b/%0d expected %b/%b/%0d",
               tag, cycles, req, active, row, e_req, m_act, m_row);
    end
    if (active) acts_after_wake++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset(logic [IW-1:0] ivl);
    tag = "R1";
    rst_n = 1'b0; interval = ivl;
    sleep = 0; mc_end = 0; grant = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    // R1 reset state
    do_reset(12'd3);

    // R2 periodic requests, always granted
    tag = "R2";
    mc_end = 1; grant = 1;
    step(40);

    // R6 sparse machine-cycle ends and grants
    tag = "R6";
    for (int i = 0; i < 60; i++) begin
      mc_end = (i % 3 == 2); grant = (i % 5 != 1);
      step(1);
    end

    // R7 merge: short period, no grant for a while
    do_reset(12'd1);
    tag = "R7";
    mc_end = 1; grant = 0;
    step(12);
    grant = 1;
    step(10);

    // R3 / R4 / R9 sleep spanning several expiries
    do_reset(12'd4);
    tag = "R3";
    mc_end = 1; grant = 1;
    step(7);
    sleep = 1; tag = "R9";
    step(23);
    // R5 replay: wait a few cycles before the first granted end
    sleep = 0; tag = "R5";
    mc_end = 0;
    acts_after_wake = 0;
    step(1);
    mc_end = 1;
    step(2);
    tag = "R4";
    vectors++;
    if (acts_after_wake != 1) begin
      errors++;
      $display("FAIL R4: strobes after wake %0d expected 1", acts_after_wake);
    end
    step(20);

    // R8 row wrap: serve every cycle
    do_reset(12'd0);
    tag = "R8";
    mc_end = 1; grant = 1;
    step(270);
    sleep = 1;
    step(5);
    sleep = 0;
    step(5);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule